// File: doc/BRIEF.md
# Transmit Start Handshake Sequencer

This block decides when an asynchronous serial transmitter may send its first start bit. It watches a transmit bit clock, a flag saying the transmit FIFO holds data, and a clear-to-send input. It drives request-to-send, a one-cycle start strobe and a count of the bit times spent waiting. All logic runs on a fast system clock. The bit clock is sampled as a level, and its falling edges mark bit boundaries.

When data is waiting and a falling bit-clock edge arrives, RTS is raised. If CTS is already high at that edge, the start strobe fires on the second falling edge after it. If CTS is low, the sequencer keeps RTS high and waits. The start delay is counted from the first falling edge at which CTS is seen high: three bit times when the sampling-mode bit is 0, or two when it is 1. After the start strobe the sequencer stays in a sending state. It drops RTS when the serializer reports the last bit of a character while the FIFO is empty.

Top module: `tx_handshake_start`

## Requirements
- R1: After reset, rts is 0, tx_start is 0 and wait_cnt is 0.
- R2: In idle with fifo_has_data = 1, rts becomes 1 in the clock cycle after a falling edge of txclk (txclk was 1 in the previous clock cycle and is 0 now).
- R3: If cts = 1 at the falling edge that raises rts, tx_start pulses after the second falling edge that follows. At that point wait_cnt reads 2.
- R4: If cts = 0 at the falling edge that raises rts, rts stays 1 and no start occurs while cts stays 0. With cts_mode = 0, tx_start pulses after the third falling edge that follows the first falling edge at which cts = 1.
- R5: Under the same conditions with cts_mode = 1, tx_start pulses after the second falling edge that follows the first falling edge at which cts = 1.
- R6: tx_start is high for exactly one clock cycle, and it pulses at most once between a rise of rts and the next fall of rts.
- R7: wait_cnt starts at 0 when rts rises and adds one at every later falling edge of txclk up to and including the start edge. It then holds its value until rts falls, and it saturates at 2^CNT_W-1 (15 by default).
- R8: After the start, a tx_last_bit pulse with fifo_has_data = 0 drops rts in the next clock cycle, and wait_cnt returns to 0 one cycle after that. A tx_last_bit pulse with fifo_has_data = 1 leaves rts at 1.
- R9: With fifo_has_data = 1 in idle, a txclk that is held steady or makes a rising edge leaves rts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txclk | input | 1 | Transmit bit clock, sampled as a level |
| fifo_has_data | input | 1 | Transmit FIFO holds at least one character |
| cts | input | 1 | Clear to send, 1 = asserted |
| cts_mode | input | 1 | CTS sampling mode: 0 = three-bit start delay, 1 = two-bit start delay |
| tx_last_bit | input | 1 | Pulse from the serializer after the last bit of a character |
| rts | output | 1 | Request to send, 1 = asserted |
| tx_start | output | 1 | One-cycle strobe: send the first start bit |
| wait_cnt | output | CNT_W | Bit times counted since rts rose |

## Verification
The hardest state to reach is saturation of the wait counter. It only happens when CTS stays low for more falling bit-clock edges than the counter can hold while RTS is already high. The stimulus raises RTS with CTS low and then delivers twenty falling edges. It checks that the count stops at 15, that RTS is still high and that no start has fired. It then releases CTS and checks that the three-bit delay still runs from that edge, with the saturated count held.

// File: rtl/txhs_pkg.sv
package txhs_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE     = 2'd0,
      SEQ_WAIT_CTS = 2'd1,
      SEQ_COUNT    = 2'd2,
      SEQ_SEND     = 2'd3
   } seq_state_t;
endpackage

// File: rtl/txhs_edge_sense.sv
// Samples the bit clock and CTS, optionally through a synchronizer chain,
// and flags falling edges of the bit clock.
module txhs_edge_sense #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txclk,
   input  logic cts,
   output logic fall,
   output logic cts_s
);
   logic tx_s;
   logic tx_prev;

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign tx_s  = txclk;
      assign cts_s = cts;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] tx_ch;
      logic [SYNC_STAGES-1:0] cts_ch;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tx_ch  <= '0;
            cts_ch <= '0;
         end else begin
            tx_ch[0]  <= txclk;
            cts_ch[0] <= cts;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               tx_ch[i]  <= tx_ch[i-1];
               cts_ch[i] <= cts_ch[i-1];
            end
         end
      end
      assign tx_s  = tx_ch[SYNC_STAGES-1];
      assign cts_s = cts_ch[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tx_prev <= 1'b0;
      else        tx_prev <= tx_s;
   end

   assign fall = tx_prev & ~tx_s;

   AST_FALL_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R2
endmodule

// File: rtl/txhs_sat_counter.sv
// Saturating up counter with synchronous clear.
module txhs_sat_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] QMAX = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("counter width must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 q <= '0;
      else if (clr)               q <= '0;
      else if (inc && q != QMAX)  q <= q + W'(1);
   end

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (q == QMAX && !clr) |=> q == QMAX); // R7
   AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(q)); // R7
endmodule

// File: rtl/tx_handshake_start.sv
// Sequencer deciding when the first start bit may go out.
module tx_handshake_start #(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 0,
   parameter int DLY_READY   = 2,
   parameter int DLY_MODE0   = 3,
   parameter int DLY_MODE1   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txclk,
   input  logic             fifo_has_data,
   input  logic             cts,
   input  logic             cts_mode,
   input  logic             tx_last_bit,
   output logic             rts,
   output logic             tx_start,
   output logic [CNT_W-1:0] wait_cnt
);
   import txhs_pkg::*;

   localparam int CNT_MAX = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] T_READY = CNT_W'(DLY_READY);
   localparam logic [CNT_W-1:0] T_MODE0 = CNT_W'(DLY_MODE0);
   localparam logic [CNT_W-1:0] T_MODE1 = CNT_W'(DLY_MODE1);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (DLY_READY < 1 || DLY_MODE0 < 1 || DLY_MODE1 < 1) begin : g_bad_dly_lo
      $error("start delays must be at least one bit time");
   end
   if (DLY_READY > CNT_MAX || DLY_MODE0 > CNT_MAX || DLY_MODE1 > CNT_MAX) begin : g_bad_dly_hi
      $error("start delays must fit in CNT_W bits");
   end

   seq_state_t       state;
   logic             fall;
   logic             cts_s;
   logic [CNT_W-1:0] target;
   logic [CNT_W-1:0] phase_q;
   logic [CNT_W-1:0] phase_next;

   txhs_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .txclk (txclk),
      .cts   (cts),
      .fall  (fall),
      .cts_s (cts_s)
   );

   // Bit times since CTS condition met.
   txhs_sat_counter #(.W(CNT_W)) i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != SEQ_COUNT),
      .inc   (state == SEQ_COUNT && fall),
      .q     (phase_q)
   );

   // Bit times since RTS rose, frozen once sending.
   txhs_sat_counter #(.W(CNT_W)) i_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == SEQ_IDLE),
      .inc   (fall && (state == SEQ_WAIT_CTS || state == SEQ_COUNT)),
      .q     (wait_cnt)
   );

   assign phase_next = phase_q + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         rts      <= 1'b0;
         tx_start <= 1'b0;
         target   <= T_READY;
      end else begin
         tx_start <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (fall && fifo_has_data) begin
                  rts    <= 1'b1;
                  target <= T_READY;
                  state  <= cts_s ? SEQ_COUNT : SEQ_WAIT_CTS;
               end
            end
            SEQ_WAIT_CTS: begin
               if (fall && cts_s) begin
                  target <= cts_mode ? T_MODE1 : T_MODE0;
                  state  <= SEQ_COUNT;
               end
            end
            SEQ_COUNT: begin
               if (fall && phase_next == target) begin
                  tx_start <= 1'b1;
                  state    <= SEQ_SEND;
               end
            end
            SEQ_SEND: begin
               if (tx_last_bit && !fifo_has_data) begin
                  rts   <= 1'b0;
                  state <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   AST_RTS_RISE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rts) |-> $past(fall && fifo_has_data)); // R2
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R6
   AST_START_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> rts); // R6
   AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(fall)); // R3
   AST_START_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> wait_cnt >= T_MODE1 || wait_cnt >= T_READY); // R3
   AST_RTS_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rts) |-> $past(tx_last_bit && !fifo_has_data)); // R8
   AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_SEND && $past(state == SEQ_SEND)) |-> $stable(wait_cnt)); // R7
endmodule

// File: tb/test_tx_handshake_start.sv
`timescale 1ns/1ps
module test_tx_handshake_start;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txclk = 1'b0;
   logic       fifo_has_data = 1'b0;
   logic       cts = 1'b0;
   logic       cts_mode = 1'b0;
   logic       tx_last_bit = 1'b0;
   logic       rts;
   logic       tx_start;
   logic [3:0] wait_cnt;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   tx_handshake_start i_tx_handshake_start (
      .clk           (clk),
      .rst_n         (rst_n),
      .txclk         (txclk),
      .fifo_has_data (fifo_has_data),
      .cts           (cts),
      .cts_mode      (cts_mode),
      .tx_last_bit   (tx_last_bit),
      .rts           (rts),
      .tx_start      (tx_start),
      .wait_cnt      (wait_cnt)
   );

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Rising then falling txclk; returns at the negedge where the result is visible.
   task automatic bit_fall();
      @(negedge clk) txclk = 1'b1;
      @(negedge clk);
      txclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic last_bit_pulse();
      @(negedge clk) tx_last_bit = 1'b1;
      @(negedge clk) tx_last_bit = 1'b0;
   endtask

   task automatic end_session();
      fifo_has_data = 1'b0;
      last_bit_pulse();
      check("R8 rts drop", rts, 0);
      @(negedge clk);
      check("R8 wait_cnt clear", wait_cnt, 0);
   endtask

   task automatic t_reset();
      check("R1 rts", rts, 0);
      check("R1 tx_start", tx_start, 0);
      check("R1 wait_cnt", wait_cnt, 0);
   endtask

   task automatic t_ready_cts();
      cts = 1'b1;
      cts_mode = 1'b0;
      fifo_has_data = 1'b1;
      repeat (4) @(negedge clk);
      check("R9 steady txclk", rts, 0);
      @(negedge clk) txclk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R9 rising txclk", rts, 0);
      txclk = 1'b0;
      @(negedge clk);
      check("R2 rts rise", rts, 1);
      check("R7 wait_cnt at rts", wait_cnt, 0);
      bit_fall();
      check("R3 no early start", tx_start, 0);
      check("R7 wait_cnt one", wait_cnt, 1);
      bit_fall();
      check("R3 start", tx_start, 1);
      check("R3 wait_cnt", wait_cnt, 2);
      @(negedge clk);
      check("R6 pulse width", tx_start, 0);
      bit_fall();
      check("R6 single start", tx_start, 0);
      check("R7 frozen", wait_cnt, 2);
      last_bit_pulse();
      @(negedge clk);
      check("R8 rts kept with data", rts, 1);
      end_session();
   endtask

   task automatic t_slow(bit mode, int exp_dly);
      int hits = 0;
      cts = 1'b0;
      cts_mode = mode;
      fifo_has_data = 1'b1;
      bit_fall();
      check("R2 rts rise", rts, 1);
      bit_fall();
      bit_fall();
      check("R4 held while cts low", rts, 1);
      check("R4 no start cts low", tx_start, 0);
      check("R7 wait count", wait_cnt, 2);
      cts = 1'b1;
      bit_fall();
      check("R7 cts seen", wait_cnt, 3);
      for (int k = 1; k <= exp_dly; k++) begin
         bit_fall();
         if (tx_start) hits++;
         if (k < exp_dly) check(mode ? "R5 early" : "R4 early", tx_start, 0);
         else             check(mode ? "R5 start" : "R4 start", tx_start, 1);
      end
      check(mode ? "R5 wait_cnt" : "R4 wait_cnt", wait_cnt, 3 + exp_dly);
      bit_fall();
      check("R6 one start", hits + tx_start, 1);
      end_session();
   endtask

   task automatic t_saturate();
      cts = 1'b0;
      cts_mode = 1'b0;
      fifo_has_data = 1'b1;
      bit_fall();
      for (int k = 0; k < 20; k++) bit_fall();
      check("R7 saturate", wait_cnt, 15);
      check("R4 rts held long", rts, 1);
      check("R4 no start long", tx_start, 0);
      cts = 1'b1;
      bit_fall();
      bit_fall();
      bit_fall();
      check("R4 no start before third", tx_start, 0);
      bit_fall();
      check("R4 start after saturate", tx_start, 1);
      check("R7 saturated value", wait_cnt, 15);
      end_session();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ready_cts();
      t_slow(1'b0, 3);
      t_slow(1'b1, 2);
      t_saturate();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule